// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequencer

This block runs transfers on a single-lane SPI flash bus from a small instruction table that software loads. Each table word holds two 16-bit instruction slots. A slot either sends an opcode, sends the flash address, idles the clock for a set number of cycles, captures read bytes into a receive buffer, or shifts bytes out of a transmit buffer. Software keeps one short program per flash operation (write enable, fast read, status read, page program and so on). It starts an operation by writing a sequence index and an optional byte count to a start register. While the engine runs, the busy flag is high.

The table is write-protected. Software must first write a key value and then an unlock command before table writes take effect. Writing the key followed by a lock command protects the table again. Read data arrives in a byte buffer that software reads back as 32-bit words. Write data is pushed as 32-bit words. An optional swap reverses the byte order inside every buffer word.

Top module: `sflash_seq`

## Requirements
- R1: After reset the status register (address 0x06) reads 0x0000_0008 (idle, locked, no error, no read data), cs_n is high and sck is low.
- R2: The table is locked out of reset. A table write while locked leaves the word unchanged. A write of 2 to address 0x02 unlocks the table and a write of 1 locks it, but each takes effect only when the write just before it was the key value to address 0x01. Status bit 3 shows the lock.
- R3: Sequence s owns table words 0x40+4s to 0x43+4s. In every word the slot in bits [15:0] runs before the slot in bits [31:16]. A slot is laid out as code [15:10], lane [9:8] and operand [7:0], with codes 1=opcode, 2=address, 3=dummy, 4=read and 5=write. Code 0 or an unknown code ends the sequence, and so does running past the eighth slot.
- R4: An opcode slot shifts its 8-bit operand MSB first in SPI mode 0: sck idles low, mosi changes only on falling edges and miso is sampled on rising edges.
- R5: An address slot with operand 32 sends all 32 bits of the flash address register (address 0x03). Any other operand sends its low 24 bits.
- R6: A dummy slot gives operand sck cycles with mosi held low.
- R7: A read slot stores the bytes it receives, in order, into a 128-byte receive buffer. Word i reads at 0x80+i with the first byte in bits [7:0]. Status bits [15:8] give the byte count and bit 1 flags that data is present.
- R8: A write slot sends bytes from the words pushed to address 0x05, bits [7:0] of the first word first. Its byte count is capped at 64.
- R9: A start write (address 0x04) takes the sequence index in bits [10:8] and a size in bits [7:0]. A nonzero size replaces the read or write operand, and zero keeps the operand.
- R10: Control bit 2 (address 0x00) reverses the byte order inside each buffer word, for receive readback and for transmit.
- R11: Control bit 0 empties the receive buffer and control bit 1 empties the transmit buffer.
- R12: Busy (status bit 0) is high from the clock after a start until the sequence ends, and cs_n is low exactly while busy is high.
- R13: A start written while busy is ignored and sets the sticky error bit (status bit 2). Control bit 3 clears that bit.
- R14: A slot with a nonzero lane field ends the sequence without clocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sck | output | 1 | Flash serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bench plays the flash. It counts sck rising edges in every transaction and compares the shifted bytes with the table program, so a wrong address width, dummy count or slot order changes the edge count or the byte order. Lock handling is tested with an unlock that has no key and with one that has a wrong key; a design that ignores the key would let table words change. A second start issued while busy must leave the first transfer's edge count intact and raise the error bit; a design that restarts would produce a short or mixed transfer. Size override, the 64-byte write cap, end after eight slots, lane-field rejection and byte swap each have their own exact edge count or word value.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam logic [7:0] REG_CTRL  = 8'h00;
    localparam logic [7:0] REG_KEY   = 8'h01;
    localparam logic [7:0] REG_LOCK  = 8'h02;
    localparam logic [7:0] REG_FADDR = 8'h03;
    localparam logic [7:0] REG_START = 8'h04;
    localparam logic [7:0] REG_TXD   = 8'h05;
    localparam logic [7:0] REG_STAT  = 8'h06;

    localparam logic [31:0] LOCK_CMD_LOCK   = 32'd1;
    localparam logic [31:0] LOCK_CMD_UNLOCK = 32'd2;

    localparam logic [5:0] OP_STOP  = 6'd0;
    localparam logic [5:0] OP_CMD   = 6'd1;
    localparam logic [5:0] OP_ADDR  = 6'd2;
    localparam logic [5:0] OP_DUMMY = 6'd3;
    localparam logic [5:0] OP_READ  = 6'd4;
    localparam logic [5:0] OP_WRITE = 6'd5;

    typedef struct packed {
        logic [5:0] code;
        logic [1:0] lane;
        logic [7:0] arg;
    } slot_t;
endpackage

// File: rtl/sfs_lut.sv
module sfs_lut #(
    parameter int          NUM_SEQ = 8,
    parameter logic [31:0] KEY     = 32'h5AF0_C3A5,
    localparam int         WORDS   = NUM_SEQ * 4,
    localparam int         IW      = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_wr,
    input  logic          key_wr,
    input  logic          lock_wr,
    input  logic          tab_wr,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] bus_idx,
    output logic [31:0]   bus_word,
    input  logic [IW-1:0] eng_idx,
    output logic [31:0]   eng_word,
    output logic          locked
);
    import sfs_pkg::*;

    typedef struct packed {
        logic armed;
        logic locked;
    } guard_t;

    guard_t      q, d;
    logic [31:0] tab [WORDS];

    always_comb begin
        d = q;
        if (key_wr) begin
            d.armed = (wdata == KEY);
        end else if (lock_wr) begin
            if (q.armed) begin
                if (wdata == LOCK_CMD_LOCK)
                    d.locked = 1'b1;
                else if (wdata == LOCK_CMD_UNLOCK)
                    d.locked = 1'b0;
            end
            d.armed = 1'b0;
        end else if (any_wr) begin
            d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.armed  <= 1'b0;
            q.locked <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) tab[i] <= '0;
        end else if (tab_wr && !q.locked) begin
            tab[bus_idx] <= wdata;
        end
    end

    assign bus_word = tab[bus_idx];
    assign eng_word = tab[eng_idx];
    assign locked   = q.locked;
endmodule

// File: rtl/sfs_bufs.sv
module sfs_bufs #(
    parameter int  RX_BYTES = 128,
    parameter int  TX_BYTES = 64,
    localparam int RXW      = RX_BYTES / 4,
    localparam int TXW      = TX_BYTES / 4,
    localparam int RCW      = $clog2(RX_BYTES + 1),
    localparam int RIW      = $clog2(RXW),
    localparam int TWW      = $clog2(TXW + 1),
    localparam int TIW      = $clog2(TXW),
    localparam int TPW      = $clog2(TX_BYTES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           swap,
    input  logic           clr_rx,
    input  logic           clr_tx,
    input  logic           rx_push,
    input  logic [7:0]     rx_byte,
    output logic [RCW-1:0] rx_cnt,
    input  logic [RIW-1:0] rx_widx,
    output logic [31:0]    rx_word,
    input  logic           tx_push,
    input  logic [31:0]    tx_word_in,
    input  logic           tx_rewind,
    input  logic           tx_pop,
    output logic [7:0]     tx_byte
);
    typedef struct packed {
        logic [RCW-1:0] rx_cnt;
        logic [TWW-1:0] tx_wcnt;
        logic [TPW-1:0] tx_rd;
    } bufst_t;

    bufst_t      q, d;
    logic [7:0]  rx_mem [RX_BYTES];
    logic [31:0] tx_mem [TXW];
    logic        rx_store, tx_store;
    logic [31:0] tx_cur;
    logic [1:0]  lane_sel;

    assign rx_store = rx_push && !clr_rx && (q.rx_cnt < RCW'(RX_BYTES));
    assign tx_store = tx_push && !clr_tx && (q.tx_wcnt < TWW'(TXW));

    always_comb begin
        d = q;
        if (clr_rx)        d.rx_cnt = '0;
        else if (rx_store) d.rx_cnt = q.rx_cnt + 1'b1;
        if (clr_tx) begin
            d.tx_wcnt = '0;
            d.tx_rd   = '0;
        end else begin
            if (tx_store)       d.tx_wcnt = q.tx_wcnt + 1'b1;
            if (tx_rewind)      d.tx_rd   = '0;
            else if (tx_pop)    d.tx_rd   = q.tx_rd + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (rx_store) rx_mem[q.rx_cnt[RIW+1:0]] <= rx_byte;
        if (tx_store) tx_mem[q.tx_wcnt[TIW-1:0]] <= tx_word_in;
    end

    always_comb begin
        if (swap)
            rx_word = {rx_mem[{rx_widx, 2'd0}], rx_mem[{rx_widx, 2'd1}],
                       rx_mem[{rx_widx, 2'd2}], rx_mem[{rx_widx, 2'd3}]};
        else
            rx_word = {rx_mem[{rx_widx, 2'd3}], rx_mem[{rx_widx, 2'd2}],
                       rx_mem[{rx_widx, 2'd1}], rx_mem[{rx_widx, 2'd0}]};
    end

    assign tx_cur   = tx_mem[q.tx_rd[TPW-1:2]];
    assign lane_sel = swap ? (2'd3 - q.tx_rd[1:0]) : q.tx_rd[1:0];
    assign tx_byte  = tx_cur[lane_sel*8 +: 8];
    assign rx_cnt   = q.rx_cnt;
endmodule

// File: rtl/sfs_engine.sv
module sfs_engine #(
    parameter int  NUM_SEQ  = 8,
    parameter int  DIV      = 2,
    parameter int  TX_BYTES = 64,
    localparam int SW       = $clog2(NUM_SEQ),
    localparam int IW       = SW + 2,
    localparam int DCW      = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [SW-1:0] start_seq,
    input  logic [7:0]    start_size,
    input  logic [31:0]   faddr,
    output logic [IW-1:0] lut_idx,
    input  logic [31:0]   lut_word,
    input  logic [7:0]    tx_byte,
    output logic          tx_pop,
    output logic          tx_rewind,
    output logic          rx_push,
    output logic [7:0]    rx_byte,
    output logic          busy,
    output logic          sck,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);
    import sfs_pkg::*;

    typedef enum logic [1:0] {E_IDLE, E_SLOT, E_BITS} est_e;

    typedef struct packed {
        est_e           st;
        logic [SW-1:0]  seq;
        logic [7:0]     size;
        logic [3:0]     slot;
        logic [31:0]    sh;
        logic [7:0]     nbits;
        logic [7:0]     left;
        logic [5:0]     kind;
        logic [DCW-1:0] hc;
        logic           sck;
        logic           csn;
        logic [7:0]     rxsh;
    } eng_t;

    eng_t       q, d;
    slot_t      cur;
    logic [7:0] cnt, wcnt;

    assign lut_idx = {q.seq, q.slot[2:1]};
    assign cur     = q.slot[0] ? slot_t'(lut_word[31:16]) : slot_t'(lut_word[15:0]);
    assign cnt     = (q.size != 8'd0) ? q.size : cur.arg;
    assign wcnt    = (cnt > 8'(TX_BYTES)) ? 8'(TX_BYTES) : cnt;

    always_comb begin
        d         = q;
        tx_pop    = 1'b0;
        tx_rewind = 1'b0;
        rx_push   = 1'b0;
        case (q.st)
            E_IDLE: begin
                if (start) begin
                    d.st      = E_SLOT;
                    d.seq     = start_seq;
                    d.size    = start_size;
                    d.slot    = 4'd0;
                    d.csn     = 1'b0;
                    tx_rewind = 1'b1;
                end
            end
            E_SLOT: begin
                d.kind = cur.code;
                d.hc   = '0;
                d.slot = q.slot + 4'd1;
                if (q.slot[3] || cur.lane != 2'd0) begin
                    d.st  = E_IDLE;
                    d.csn = 1'b1;
                end else begin
                    case (cur.code)
                        OP_CMD: begin
                            d.sh    = {cur.arg, 24'h0};
                            d.nbits = 8'd8;
                            d.slot  = q.slot;
                            d.st    = E_BITS;
                        end
                        OP_ADDR: begin
                            d.sh    = (cur.arg == 8'd32) ? faddr : {faddr[23:0], 8'h0};
                            d.nbits = (cur.arg == 8'd32) ? 8'd32 : 8'd24;
                            d.slot  = q.slot;
                            d.st    = E_BITS;
                        end
                        OP_DUMMY: begin
                            if (cur.arg != 8'd0) begin
                                d.sh    = '0;
                                d.nbits = cur.arg;
                                d.slot  = q.slot;
                                d.st    = E_BITS;
                            end
                        end
                        OP_READ: begin
                            if (cnt != 8'd0) begin
                                d.sh    = '0;
                                d.nbits = 8'd8;
                                d.left  = cnt;
                                d.slot  = q.slot;
                                d.st    = E_BITS;
                            end
                        end
                        OP_WRITE: begin
                            if (wcnt != 8'd0) begin
                                d.sh    = {tx_byte, 24'h0};
                                tx_pop  = 1'b1;
                                d.nbits = 8'd8;
                                d.left  = wcnt;
                                d.slot  = q.slot;
                                d.st    = E_BITS;
                            end
                        end
                        default: begin
                            d.st  = E_IDLE;
                            d.csn = 1'b1;
                        end
                    endcase
                end
            end
            E_BITS: begin
                if (q.hc == DCW'(DIV - 1)) begin
                    d.hc = '0;
                    if (!q.sck) begin
                        d.sck  = 1'b1;
                        d.rxsh = {q.rxsh[6:0], miso};
                    end else begin
                        d.sck   = 1'b0;
                        d.sh    = {q.sh[30:0], 1'b0};
                        d.nbits = q.nbits - 8'd1;
                        if (q.nbits == 8'd1) begin
                            if (q.kind == OP_READ || q.kind == OP_WRITE) begin
                                rx_push = (q.kind == OP_READ);
                                d.left  = q.left - 8'd1;
                                if (q.left > 8'd1) begin
                                    d.nbits = 8'd8;
                                    if (q.kind == OP_WRITE) begin
                                        d.sh   = {tx_byte, 24'h0};
                                        tx_pop = 1'b1;
                                    end
                                end else begin
                                    d.slot = q.slot + 4'd1;
                                    d.st   = E_SLOT;
                                end
                            end else begin
                                d.slot = q.slot + 4'd1;
                                d.st   = E_SLOT;
                            end
                        end
                    end
                end else begin
                    d.hc = q.hc + 1'b1;
                end
            end
            default: d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_byte = q.rxsh;
    assign busy    = (q.st != E_IDLE);
    assign sck     = q.sck;
    assign cs_n    = q.csn;
    assign mosi    = q.sh[31];
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq #(
    parameter int          NUM_SEQ  = 8,
    parameter int          RX_BYTES = 128,
    parameter int          TX_BYTES = 64,
    parameter int          DIV      = 2,
    parameter logic [31:0] KEY      = 32'h5AF0_C3A5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sck,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    import sfs_pkg::*;

    localparam int SW        = $clog2(NUM_SEQ);
    localparam int LUT_WORDS = NUM_SEQ * 4;
    localparam int IW        = $clog2(LUT_WORDS);
    localparam int RX_WORDS  = RX_BYTES / 4;
    localparam int RIW       = $clog2(RX_WORDS);
    localparam int RCW       = $clog2(RX_BYTES + 1);

    typedef struct packed {
        logic [31:0] faddr;
        logic        swap;
        logic        err;
    } top_t;

    top_t q, d;

    logic           wr_ctrl, wr_key, wr_lock, wr_faddr, wr_start, wr_txd, wr_lut;
    logic           lut_sel, rx_sel;
    logic           busy, locked, err_flag, start_ok;
    logic [31:0]    lut_bus_word, lut_eng_word, rx_word;
    logic [IW-1:0]  eng_idx;
    logic [RCW-1:0] rx_cnt;
    logic [7:0]     tx_byte, rx_byte;
    logic           tx_pop, tx_rewind, rx_push;

    assign lut_sel  = (bus_addr[7:6] == 2'b01) && (bus_addr[5:0] < 6'(LUT_WORDS));
    assign rx_sel   = (bus_addr[7:6] == 2'b10) && (bus_addr[5:0] < 6'(RX_WORDS));
    assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
    assign wr_key   = bus_wr && (bus_addr == REG_KEY);
    assign wr_lock  = bus_wr && (bus_addr == REG_LOCK);
    assign wr_faddr = bus_wr && (bus_addr == REG_FADDR);
    assign wr_start = bus_wr && (bus_addr == REG_START);
    assign wr_txd   = bus_wr && (bus_addr == REG_TXD);
    assign wr_lut   = bus_wr && lut_sel;
    assign start_ok = wr_start && !busy;
    assign err_flag = q.err;

    always_comb begin
        d = q;
        if (wr_faddr) d.faddr = bus_wdata;
        if (wr_ctrl) begin
            d.swap = bus_wdata[2];
            if (bus_wdata[3]) d.err = 1'b0;
        end
        if (wr_start && busy) d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sfs_lut #(.NUM_SEQ(NUM_SEQ), .KEY(KEY)) i_lut (
        .clk(clk), .rst_n(rst_n), .any_wr(bus_wr), .key_wr(wr_key),
        .lock_wr(wr_lock), .tab_wr(wr_lut), .wdata(bus_wdata),
        .bus_idx(bus_addr[IW-1:0]), .bus_word(lut_bus_word),
        .eng_idx(eng_idx), .eng_word(lut_eng_word), .locked(locked)
    );

    sfs_bufs #(.RX_BYTES(RX_BYTES), .TX_BYTES(TX_BYTES)) i_bufs (
        .clk(clk), .rst_n(rst_n), .swap(q.swap),
        .clr_rx(wr_ctrl && bus_wdata[0]), .clr_tx(wr_ctrl && bus_wdata[1]),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_cnt(rx_cnt),
        .rx_widx(bus_addr[RIW-1:0]), .rx_word(rx_word),
        .tx_push(wr_txd), .tx_word_in(bus_wdata), .tx_rewind(tx_rewind),
        .tx_pop(tx_pop), .tx_byte(tx_byte)
    );

    sfs_engine #(.NUM_SEQ(NUM_SEQ), .DIV(DIV), .TX_BYTES(TX_BYTES)) i_eng (
        .clk(clk), .rst_n(rst_n), .start(start_ok),
        .start_seq(bus_wdata[SW+7:8]), .start_size(bus_wdata[7:0]),
        .faddr(q.faddr), .lut_idx(eng_idx), .lut_word(lut_eng_word),
        .tx_byte(tx_byte), .tx_pop(tx_pop), .tx_rewind(tx_rewind),
        .rx_push(rx_push), .rx_byte(rx_byte), .busy(busy),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_STAT)
            bus_rdata = (32'(rx_cnt) << 8) |
                        {28'h0, locked, q.err, (rx_cnt != '0), busy};
        else if (bus_addr == REG_FADDR)
            bus_rdata = q.faddr;
        else if (bus_addr == REG_CTRL)
            bus_rdata = {29'h0, q.swap, 2'b00};
        else if (lut_sel)
            bus_rdata = lut_bus_word;
        else if (rx_sel)
            bus_rdata = rx_word;
    end
endmodule

// File: rtl/sfs_seq_chk.sv
module sfs_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       mosi,
    input logic       busy,
    input logic       locked,
    input logic       err,
    input logic       bus_wr,
    input logic [7:0] bus_addr
);
    import sfs_pkg::*;

    AST_SCK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R4

    AST_MOSI_HOLDS_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi)); // R4

    AST_CS_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !cs_n); // R12

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == REG_START)); // R12

    AST_UNLOCK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(bus_wr && bus_addr == REG_LOCK)); // R2

    AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == REG_START) |=> err); // R13
endmodule

bind sflash_seq sfs_seq_chk i_sfs_seq_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .busy(busy), .locked(locked), .err(err_flag),
    .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/test_sflash_seq.sv
module test_sflash_seq;
    localparam logic [31:0] KEYV = 32'h5AF0_C3A5;
    localparam logic [5:0] C_CMD = 6'd1, C_ADDR = 6'd2, C_DUM = 6'd3, C_RD = 6'd4, C_WR = 6'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, cs_n, mosi, miso;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    logic cap [0:2047];
    int   nbits = 0;
    int   obit = 0;
    int   stray = 0;

    always #5 clk = ~clk;

    sflash_seq i_sflash_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    function automatic logic [7:0] resp(input int k);
        return 8'((k * 8'h13 + 8'h5C) & 8'hFF);
    endfunction

    function automatic logic [15:0] sl(input logic [5:0] c, input logic [7:0] a);
        return {c, 2'b00, a};
    endfunction

    // flash model
    always @(negedge cs_n) begin nbits = 0; obit = 0; end
    always @(posedge sck) begin
        if (cs_n) stray++;
        else begin
            if (nbits < 2048) cap[nbits] = mosi;
            nbits++;
        end
    end
    always @(negedge sck) obit++;
    assign miso = cs_n ? 1'b0 : resp(obit / 8)[7 - (obit % 8)];

    function automatic logic [7:0] mbyte(input int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7 - i] = cap[8 * k + i];
        return b;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 10000; i++) begin
            rd(8'h06, s);
            if (!s[0]) return;
        end
    endtask

    task automatic run(input int seq, input int size);
        wr(8'h04, 32'((seq << 8) | size));
        wait_idle();
    endtask

    task automatic t_reset();
        logic [31:0] s;
        rd(8'h06, s);
        check("R1 status", s, 32'h8);
        check("R1 cs_n", {31'h0, cs_n}, 32'h1);
        check("R1 sck", {31'h0, sck}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        wr(8'h44, 32'hDEAD);
        rd(8'h44, v);
        check("R2 locked write ignored", v, 32'h0);
        wr(8'h02, 32'd2);
        rd(8'h06, v);
        check("R2 unlock without key", {31'h0, v[3]}, 32'h1);
        wr(8'h01, 32'h1234_5678);
        wr(8'h02, 32'd2);
        rd(8'h06, v);
        check("R2 unlock with wrong key", {31'h0, v[3]}, 32'h1);
        wr(8'h01, KEYV);
        wr(8'h02, 32'd2);
        rd(8'h06, v);
        check("R2 unlock with key", {31'h0, v[3]}, 32'h0);
    endtask

    task automatic t_program();
        logic [31:0] v;
        wr(8'h44, {16'h0, sl(C_CMD, 8'h06)});
        wr(8'h48, {sl(C_ADDR, 8'd24), sl(C_CMD, 8'h0B)});
        wr(8'h49, {sl(C_RD, 8'd16), sl(C_DUM, 8'd8)});
        wr(8'h4C, {sl(C_ADDR, 8'd32), sl(C_CMD, 8'h02)});
        wr(8'h4D, {16'h0, sl(C_WR, 8'd8)});
        for (int i = 0; i < 4; i++)
            wr(8'(8'h50 + i), {sl(C_CMD, 8'(8'hA1 + 2 * i)), sl(C_CMD, 8'(8'hA0 + 2 * i))});
        wr(8'h54, {16'h0, sl(C_WR, 8'd0)});
        wr(8'h58, {sl(C_CMD, 8'h77), 6'd1, 2'b01, 8'h55});
        rd(8'h49, v);
        check("R3 table readback", v, {sl(C_RD, 8'd16), sl(C_DUM, 8'd8)});
    endtask

    task automatic t_cmd();
        run(1, 0);
        check("R4 opcode edge count", 32'(nbits), 32'd8);
        check("R4 opcode byte", {24'h0, mbyte(0)}, 32'h06);
        check("R4 no sck while deselected", 32'(stray), 32'd0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        wr(8'h00, 32'h1);
        wr(8'h03, 32'h0012_3456);
        run(2, 0);
        check("R6 read edge count", 32'(nbits), 32'd168);
        check("R5 addr24 bytes", {mbyte(0), mbyte(1), mbyte(2), mbyte(3)}, 32'h0B12_3456);
        check("R6 dummy mosi low", {24'h0, mbyte(4)}, 32'h0);
        rd(8'h06, v);
        check("R7 rx count and flag", {16'h0, v[15:8], 6'h0, v[1], 1'b0}, {16'h0, 8'd16, 8'h02});
        for (int j = 0; j < 4; j++) begin
            rd(8'(8'h80 + j), v);
            check("R7 rx word", v, {resp(8 + 4 * j), resp(7 + 4 * j), resp(6 + 4 * j), resp(5 + 4 * j)});
        end
    endtask

    task automatic t_size_swap();
        logic [31:0] v;
        wr(8'h00, 32'h1);
        run(2, 4);
        check("R9 size override edges", 32'(nbits), 32'd72);
        rd(8'h06, v);
        check("R9 size override count", {24'h0, v[15:8]}, 32'd4);
        wr(8'h00, 32'h4);
        rd(8'h80, v);
        check("R10 swapped rx word", v, {resp(5), resp(6), resp(7), resp(8)});
        wr(8'h00, 32'h1);
        rd(8'h06, v);
        check("R11 rx cleared", {16'h0, v[15:8], 6'h0, v[1], 1'b0}, 32'h0);
    endtask

    task automatic t_write();
        wr(8'h00, 32'h2);
        wr(8'h05, 32'h4433_2211);
        wr(8'h05, 32'h8877_6655);
        wr(8'h03, 32'h0A0B_0C0D);
        run(3, 8);
        check("R8 write edge count", 32'(nbits), 32'd104);
        check("R5 addr32 bytes", {mbyte(1), mbyte(2), mbyte(3), mbyte(4)}, 32'h0A0B_0C0D);
        check("R8 write bytes lo", {mbyte(5), mbyte(6), mbyte(7), mbyte(8)}, 32'h1122_3344);
        check("R8 write bytes hi", {mbyte(9), mbyte(10), mbyte(11), mbyte(12)}, 32'h5566_7788);
        wr(8'h00, 32'h6);
        wr(8'h05, 32'h4433_2211);
        run(5, 4);
        check("R10 swapped tx bytes", {mbyte(0), mbyte(1), mbyte(2), mbyte(3)}, 32'h4433_2211);
        wr(8'h00, 32'h0);
        run(5, 100);
        check("R8 write cap 64 bytes", 32'(nbits), 32'd512);
    endtask

    task automatic t_busy_err();
        logic [31:0] v;
        wr(8'h04, 32'h0000_0200);
        wr(8'h04, 32'h0000_0100);
        rd(8'h06, v);
        check("R13 error set", {29'h0, v[2], 1'b0, v[0]}, 32'h5);
        check("R12 cs low while busy", {31'h0, cs_n}, 32'h0);
        wait_idle();
        check("R13 second start ignored", 32'(nbits), 32'd168);
        check("R13 first opcode kept", {24'h0, mbyte(0)}, 32'h0B);
        check("R12 cs high when idle", {31'h0, cs_n}, 32'h1);
        wr(8'h00, 32'h8);
        rd(8'h06, v);
        check("R13 error cleared", {31'h0, v[2]}, 32'h0);
    endtask

    task automatic t_slots();
        run(4, 0);
        check("R3 eight slots edges", 32'(nbits), 32'd64);
        check("R3 slot order", {mbyte(0), mbyte(1), mbyte(2), mbyte(3)}, 32'hA0A1_A2A3);
        check("R3 slot order tail", {mbyte(4), mbyte(5), mbyte(6), mbyte(7)}, 32'hA4A5_A6A7);
        nbits = 99;
        run(6, 0);
        check("R14 lane field ends", 32'(nbits), 32'd0);
    endtask

    task automatic t_relock();
        logic [31:0] v;
        wr(8'h01, KEYV);
        wr(8'h02, 32'd1);
        rd(8'h06, v);
        check("R2 relocked", {31'h0, v[3]}, 32'h1);
        wr(8'h44, 32'h0);
        rd(8'h44, v);
        check("R2 relocked write ignored", v, {16'h0, sl(C_CMD, 8'h06)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_program();
        t_cmd();
        t_read();
        t_size_swap();
        t_write();
        t_busy_err();
        t_slots();
        t_relock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule